// File: doc/BRIEF.md
# CCK Phase Encoder with Differential First Phase

This block turns each byte of the high-rate complementary-code modulation into the four phase values that drive the code-chip generator. Every phase is a 2-bit quadrant index in units of π/2, and all phase arithmetic wraps modulo 4. The bits of a byte are taken least significant first: `in_data[0]` is d0, the earliest bit in time, and `in_data[7]` is d7.

The three later phases come straight from their dibits through a plain binary map. The first phase is differential. The block adds a phase step, chosen by the first dibit through a Gray-ordered table, to the first phase of the previous symbol. Odd-numbered symbols get an extra half turn. A start-of-packet marker on the incoming byte restarts the symbol count at zero (even). The same marker loads the reference phase from `ref_phase`, so after a change of rate the differential chain carries on from the last symbol of this modulation. Bytes come in through a valid/ready handshake. The phase set leaves one cycle later through a registered valid/ready stage that holds its value while the consumer stalls it.

Top module: `cck_phase_enc`

## Requirements
- R1: `in_ready` is high exactly when the block is out of reset and either `out_valid` is low or `out_ready` is high. A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R2: After an accepted byte, `out_valid` is high in the next cycle. It falls after a cycle with `out_valid` and `out_ready` high in which no byte is accepted.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` and all four phase outputs hold their values.
- R4: Phases 2 to 4 use a binary map. `out_phi2` = {d2,d3}, `out_phi3` = {d4,d5}, `out_phi4` = {d6,d7}, with the earlier bit as the MSB, so 00→0, 01→1 (π/2), 10→2 (π), 11→3 (3π/2).
- R5: The phase step for phase 1 uses a Gray map of {d0,d1}, with d0 as the MSB: 00→0, 01→1, 11→2, 10→3.
- R6: A byte accepted with `in_sop` high is symbol 0 (even). Its `out_phi1` = `ref_phase` + step, modulo 4.
- R7: A byte accepted with `in_sop` low takes the symbol number after that of the previously accepted byte. Its `out_phi1` = previous `out_phi1` + step + (2 if the symbol number is odd), modulo 4.
- R8: `ref_phase` has no effect on a byte accepted with `in_sop` low.
- R9: While reset is asserted, `out_valid` and `in_ready` are low. Once reset is released, `in_ready` rises and `out_valid` stays low until a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Symbol byte, bit 0 earliest in time |
| in_sop | input | 1 | Byte is the first symbol of a packet |
| ref_phase | input | 2 | Reference first phase, used with `in_sop` |
| out_valid | output | 1 | Phase set valid |
| out_ready | input | 1 | Consumer takes the phase set |
| out_phi1 | output | 2 | Differential first phase |
| out_phi2 | output | 2 | Second phase |
| out_phi3 | output | 2 | Third phase |
| out_phi4 | output | 2 | Fourth phase |

## Verification
The assertions check on every cycle that the output stage behaves as a handshake should: a stalled output holds, an accepted byte appears, an idle consumed output drops, and input readiness follows the output stage. They also check each phase against the ports one cycle earlier, including the differential first phase, with the parity that the checker tracks itself. Only the bench scenarios show the full input space: every byte under every reference at packet start, a long packet that cycles through odd and even symbols while `ref_phase` changes, and a stall in which a waiting byte must not get past a held output.

// File: rtl/cck_enc_pkg.sv
package cck_enc_pkg;
  localparam int QW     = 2;
  localparam int LANES  = 4;
  localparam int BYTE_W = QW * LANES;

  typedef logic [QW-1:0] quad_t;

  localparam quad_t HALF_TURN = quad_t'(1 << (QW - 1));
endpackage

// File: rtl/cck_rst_sync.sv
module cck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cck_dibit_lane.sv
module cck_dibit_lane
  import cck_enc_pkg::*;
#(
  parameter bit GRAY = 1'b0
) (
  input  logic  bit_early,
  input  logic  bit_late,
  output quad_t quad
);
  quad_t code;
  assign code = {bit_early, bit_late};

  generate
    if (GRAY) begin : g_gray
      quad_t bin;
      always_comb begin
        bin[QW-1] = code[QW-1];
        for (int i = QW - 2; i >= 0; i--) begin
          bin[i] = bin[i+1] ^ code[i];
        end
      end
      assign quad = bin;
    end else begin : g_bin
      assign quad = code;
    end
  endgenerate
endmodule

// File: rtl/cck_phi1_track.sv
module cck_phi1_track
  import cck_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  sop,
  input  quad_t ref_phase,
  input  quad_t step,
  output quad_t phi1
);
  quad_t phi1_q, phi1_d;
  logic  odd_next_q, odd_next_d;
  logic  odd_cur;
  quad_t base;

  always_comb begin
    odd_cur    = sop ? 1'b0 : odd_next_q;
    base       = sop ? ref_phase : phi1_q;
    phi1_d     = phi1_q;
    odd_next_d = odd_next_q;
    if (load_en) begin
      phi1_d     = base + step + (odd_cur ? HALF_TURN : quad_t'(0));
      odd_next_d = ~odd_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi1_q     <= '0;
      odd_next_q <= 1'b0;
    end else begin
      phi1_q     <= phi1_d;
      odd_next_q <= odd_next_d;
    end
  end

  assign phi1 = phi1_q;
endmodule

// File: rtl/cck_phase_enc.sv
module cck_phase_enc
  import cck_enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic [QW-1:0]     ref_phase,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QW-1:0]     out_phi1,
  output logic [QW-1:0]     out_phi2,
  output logic [QW-1:0]     out_phi3,
  output logic [QW-1:0]     out_phi4
);
  logic  rst_n_s;
  logic  accept;
  logic  valid_q, valid_d;
  quad_t lane_quad [LANES];
  quad_t data_q [LANES-1];
  quad_t data_d [LANES-1];

  cck_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign in_ready = rst_n_s && (!valid_q || out_ready);
  assign accept   = in_valid && in_ready;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      cck_dibit_lane #(.GRAY(g == 0)) u_lane (
        .bit_early (in_data[2*g]),
        .bit_late  (in_data[2*g+1]),
        .quad      (lane_quad[g])
      );
    end
  endgenerate

  cck_phi1_track u_phi1 (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_en   (accept),
    .sop       (in_sop),
    .ref_phase (ref_phase),
    .step      (lane_quad[0]),
    .phi1      (out_phi1)
  );

  always_comb begin
    valid_d = valid_q;
    if (accept)         valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    for (int k = 0; k < LANES - 1; k++) begin
      data_d[k] = accept ? lane_quad[k+1] : data_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      for (int k = 0; k < LANES - 1; k++) data_q[k] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int k = 0; k < LANES - 1; k++) data_q[k] <= data_d[k];
    end
  end

  assign out_valid = valid_q;
  assign out_phi2  = data_q[0];
  assign out_phi3  = data_q[1];
  assign out_phi4  = data_q[2];
endmodule

// File: rtl/cck_phase_enc_chk.sv
module cck_phase_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sop,
  input logic [1:0] ref_phase,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_phi1,
  input logic [1:0] out_phi2,
  input logic [1:0] out_phi3,
  input logic [1:0] out_phi4
);
  logic acc;
  logic odd_q;
  assign acc = in_valid && in_ready;

  function automatic logic [1:0] step_of(input logic [7:0] d);
    case ({d[0], d[1]})
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] sum3(input logic [1:0] a, input logic [1:0] b, input logic odd);
    logic [1:0] s;
    s = a + b;
    return s + (odd ? 2'd2 : 2'd0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   odd_q <= 1'b0;
    else if (acc) odd_q <= in_sop ? 1'b1 : ~odd_q;
  end

  assert_ready_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phi1) && $stable(out_phi2)
                                   && $stable(out_phi3) && $stable(out_phi4)));

  assert_binary_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_phi2 == {$past(in_data[2]), $past(in_data[3])}
          && out_phi3 == {$past(in_data[4]), $past(in_data[5])}
          && out_phi4 == {$past(in_data[6]), $past(in_data[7])}));

  assert_sop_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sop) |=> out_phi1 == sum3($past(ref_phase), step_of($past(in_data)), 1'b0));

  assert_diff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sop) |=> out_phi1 == sum3($past(out_phi1), step_of($past(in_data)), $past(odd_q)));

  always_comb begin
    if (!rst_n) assert_reset_idle_R9: assert (!out_valid);
  end
endmodule

bind cck_phase_enc cck_phase_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_sop    (in_sop),
  .ref_phase (ref_phase),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_phi1  (out_phi1),
  .out_phi2  (out_phi2),
  .out_phi3  (out_phi3),
  .out_phi4  (out_phi4)
);

// File: tb/cck_phase_enc_bench.sv
`timescale 1ns/1ps
module cck_phase_enc_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sop, out_valid, out_ready;
  logic [7:0] in_data;
  logic [1:0] ref_phase, out_phi1, out_phi2, out_phi3, out_phi4;

  int n_checks = 0;
  int n_fails  = 0;
  logic [1:0] m_phi1;
  logic       m_odd_next;

  always #4 clk = ~clk;

  cck_phase_enc u_cck_phase_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .ref_phase(ref_phase),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_phi1(out_phi1), .out_phi2(out_phi2), .out_phi3(out_phi3), .out_phi4(out_phi4)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] gstep(input logic [7:0] d);
    logic [1:0] c;
    c = {d[0], d[1]};
    return (c == 2'b00) ? 2'd0 : (c == 2'b01) ? 2'd1 : (c == 2'b11) ? 2'd2 : 2'd3;
  endfunction

  function automatic void model(input logic [7:0] d, input logic sop, input logic [1:0] r);
    logic odd;
    logic [1:0] base;
    odd  = sop ? 1'b0 : m_odd_next;
    base = sop ? r : m_phi1;
    m_phi1 = 2'((int'(base) + int'(gstep(d)) + (odd ? 2 : 0)) % 4);
    m_odd_next = ~odd;
  endfunction

  task automatic check_out(input logic [7:0] d, input string tag1);
    check("R2 out_valid", int'(out_valid), 1);
    check(tag1, int'(out_phi1), int'(m_phi1));
    check("R4 phi2", int'(out_phi2), int'({d[2], d[3]}));
    check("R4 phi3", int'(out_phi3), int'({d[4], d[5]}));
    check("R4 phi4", int'(out_phi4), int'({d[6], d[7]}));
  endtask

  task automatic send(input logic [7:0] d, input logic sop, input logic [1:0] r, input string tag1);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = sop; ref_phase = r; out_ready = 1'b1;
    check("R1 ready", int'(in_ready), 1);
    model(d, sop, r);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(d, tag1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sop = 1'b0;
    ref_phase = '0; out_ready = 1'b1; m_phi1 = '0; m_odd_next = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", int'(out_valid), 0);
    check("R9 reset in_ready", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 post-reset in_ready", int'(in_ready), 1);
    check("R9 post-reset out_valid", int'(out_valid), 0);

    // R5 R6: every byte as symbol 0 under every reference
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 256; b++) begin
        send(8'(b), 1'b1, 2'(r), "R5/R6 phi1 at sop");
      end
    end
    @(negedge clk);
    check("R2 drain", int'(out_valid), 0);

    // R7 R8: long packet, ref_phase varies on non-sop bytes
    send(8'h5A, 1'b1, 2'd3, "R6 phi1 at sop");
    for (int i = 0; i < 256; i++) begin
      send(8'((i * 37 + 11) % 256), 1'b0, 2'(i), "R7/R8 phi1 differential");
    end
    @(negedge clk);
    check("R2 drain", int'(out_valid), 0);

    // R1 R3: stall with a waiting byte
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hC6; in_sop = 1'b1; ref_phase = 2'd1; out_ready = 1'b0;
    model(8'hC6, 1'b1, 2'd1);
    @(negedge clk);
    check_out(8'hC6, "R6 phi1 stalled symbol");
    in_data = 8'h39; in_sop = 1'b0; ref_phase = 2'd2;
    for (int k = 0; k < 3; k++) begin
      check("R1 blocked", int'(in_ready), 0);
      @(negedge clk);
      check_out(8'hC6, "R3 held phi1");
    end
    out_ready = 1'b1;
    model(8'h39, 1'b0, 2'd2);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(8'h39, "R7 odd after stall");
    @(negedge clk);
    check("R2 drain", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule